// File: doc/BRIEF.md
# Datapath Reset Handshake Sequencer

This controller owns the three active-low reset requests of an Ethernet MAC/PCS core: one full-core reset and one reset each for the transmit and receive datapaths. The core answers each request with its own active-low acknowledge. It also reports two readiness levels: transmit lanes stable and receive PCS ready. The controller never relies on fixed delays. Each step moves on only when the core has answered the previous one.

A `start` pulse in idle begins a run. First the datapath requests are released, and then the full-core request one cycle later. The controller waits for the full-core acknowledge to clear. That alone does not mean the core works, so it then waits until both readiness levels are high. A 3-bit mode mask, latched at start, picks the optional cycles that follow, always in this order: bit 0 cycles the TX datapath, bit 1 cycles the RX datapath, and bit 2 puts the whole core into reset and leaves it there. A one-cycle `done` pulse closes a good run.

Every wait state has a timeout of `tmo_lim` cycles. When it expires, the controller asserts all three requests, raises a sticky error flag, reports which wait failed and returns to idle. All five core inputs pass through two-flop synchronizers before the state machine sees them.

Top module: `rst_hs_seq`

## Requirements
- R1: While and after the asynchronous controller reset, with no start, all three request outputs are low (asserted), and `busy`, `done`, `err` and `err_step` are zero.
- R2: A start accepted in idle releases `tx_req_n` and `rx_req_n` first. `core_req_n` rises only while both of those are already high.
- R3: After the full-core acknowledge clears, no optional cycle begins and `done` is not issued until `tx_stable` and `rx_ready` have both been seen high.
- R4: With mode bit 0 set, `tx_req_n` goes low and is released only after `tx_stable` has dropped and `tx_ack_n` has then been seen low. Afterwards the controller waits for `tx_stable` to return high.
- R5: With mode bit 1 set, `rx_req_n` goes low and is released only after `rx_ready` has dropped and `rx_ack_n` has then been seen low. Afterwards the controller waits for `rx_ready` to return high.
- R6: With mode bit 2 set, `core_req_n` goes low. `done` follows only after both readiness levels have dropped and `core_ack_n` has then gone low, and `core_req_n` stays low after the run. With bit 2 clear, all three requests end high.
- R7: The optional cycles run in the fixed order TX, RX, full. With mode 0, `done` follows bring-up directly.
- R8: `done` is high for exactly one cycle per good run. `busy` is high from acceptance until that cycle.
- R9: If a wait condition is still unmet after `tmo_lim`+1 cycles in that wait state, the same edge drives all three requests low, sets `err` and clears `busy`, and no `done` is issued.
- R10: On timeout, `err_step` holds the failed wait: 2 full-core acknowledge clear, 3 both ready, 4 TX stable drop, 5 TX acknowledge, 6 TX stable return, 7 RX ready drop, 8 RX acknowledge, 9 RX ready return, 10 both readiness drop, 11 full-core acknowledge assert.
- R11: `err` and `err_step` hold their values until the next accepted start, which clears both.
- R12: A start while `busy` is ignored. The running sequence keeps the mode latched at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| arst_n | input | 1 | Asynchronous controller reset, active low |
| start | input | 1 | Begin a run (accepted in idle only) |
| mode | input | 3 | Optional cycles: bit 0 TX, bit 1 RX, bit 2 full core |
| tmo_lim | input | TMO_W | Timeout limit for each wait state, in cycles |
| core_ack_n | input | 1 | Full-core reset acknowledge from the core, active low |
| tx_ack_n | input | 1 | TX datapath reset acknowledge, active low |
| rx_ack_n | input | 1 | RX datapath reset acknowledge, active low |
| tx_stable | input | 1 | TX lanes stable status |
| rx_ready | input | 1 | RX PCS ready status |
| core_req_n | output | 1 | Full-core reset request, active low, registered |
| tx_req_n | output | 1 | TX datapath reset request, active low, registered |
| rx_req_n | output | 1 | RX datapath reset request, active low, registered |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes without error |
| err | output | 1 | Sticky timeout flag |
| err_step | output | 4 | Code of the wait that timed out |

## Verification
A wrong state in this controller shows up at the request pins as a handshake out of order. Examples are a request released before its acknowledge, or the full-core request rising under a held datapath request. The bench catches these on the cycle the pin moves. A state that skips or repeats a step changes the order of request falls or the number of `done` pulses, and this is visible by the end of that run. A timer or step-code fault shows up as an error edge that is not exactly `tmo_lim`+1 cycles after the wait was entered, or as a wrong `err_step` value in the first idle cycle after the timeout.

// File: rtl/rst_hs_pkg.sv
package rst_hs_pkg;

  // State codes double as err_step values for the wait states.
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PREP   = 4'd1,
    ST_CREL   = 4'd2,
    ST_RDY    = 4'd3,
    ST_TXDROP = 4'd4,
    ST_TXACK  = 4'd5,
    ST_TXUP   = 4'd6,
    ST_RXDROP = 4'd7,
    ST_RXACK  = 4'd8,
    ST_RXUP   = 4'd9,
    ST_FDROP  = 4'd10,
    ST_FACK   = 4'd11
  } hs_state_e;

  localparam int MODE_W   = 3;
  localparam int NUM_SYNC = 5;

  // Index of each synchronized input in the shared vector.
  localparam int SI_CACK = 0;
  localparam int SI_TACK = 1;
  localparam int SI_RACK = 2;
  localparam int SI_TST  = 3;
  localparam int SI_RRDY = 4;

  // Phase that follows a finished stage: 0 bring-up, 1 TX cycle, 2 RX cycle.
  function automatic hs_state_e next_phase(input logic [MODE_W-1:0] m,
                                           input logic [1:0] stage);
    if (stage == 2'd0 && m[0]) return ST_TXDROP;
    if (stage <= 2'd1 && m[1]) return ST_RXDROP;
    if (m[2])                  return ST_FDROP;
    return ST_IDLE;
  endfunction

  function automatic logic is_wait(input hs_state_e s);
    return (s >= ST_CREL) && (s <= ST_FACK);
  endfunction

endpackage

// File: rtl/rst_hs_sync.sv
module rst_hs_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/rst_hs_tmo.sv
module rst_hs_tmo #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         restart,
  input  logic [W-1:0] lim,
  output logic         expire
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)               cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = (cnt_q >= lim);

  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!arst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/rst_hs_fsm.sv
module rst_hs_fsm
  import rst_hs_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              expire,
  input  logic              core_ack_s,
  input  logic              tx_ack_s,
  input  logic              rx_ack_s,
  input  logic              tx_st_s,
  input  logic              rx_rdy_s,
  output logic              core_req_n,
  output logic              tx_req_n,
  output logic              rx_req_n,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        err_step,
  output logic              restart
);
  hs_state_e         st_q, st_d;
  logic [MODE_W-1:0] mode_q;
  logic              met, wait_st, step_ok, tmo_hit, start_acc, finish;

  assign start_acc = (st_q == ST_IDLE) && start;
  assign wait_st   = is_wait(st_q);
  assign step_ok   = wait_st && met;
  assign tmo_hit   = wait_st && !met && expire;
  assign busy      = (st_q != ST_IDLE);

  always_comb begin
    unique case (st_q)
      ST_CREL:   met = core_ack_s;
      ST_RDY:    met = tx_st_s && rx_rdy_s;
      ST_TXDROP: met = !tx_st_s;
      ST_TXACK:  met = !tx_ack_s;
      ST_TXUP:   met = tx_st_s;
      ST_RXDROP: met = !rx_rdy_s;
      ST_RXACK:  met = !rx_ack_s;
      ST_RXUP:   met = rx_rdy_s;
      ST_FDROP:  met = !tx_st_s && !rx_rdy_s;
      ST_FACK:   met = !core_ack_s;
      default:   met = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    if (start_acc)              st_d = ST_PREP;
    else if (st_q == ST_PREP)   st_d = ST_CREL;
    else if (tmo_hit)           st_d = ST_IDLE;
    else if (step_ok) begin
      unique case (st_q)
        ST_CREL:   st_d = ST_RDY;
        ST_RDY:    st_d = next_phase(mode_q, 2'd0);
        ST_TXDROP: st_d = ST_TXACK;
        ST_TXACK:  st_d = ST_TXUP;
        ST_TXUP:   st_d = next_phase(mode_q, 2'd1);
        ST_RXDROP: st_d = ST_RXACK;
        ST_RXACK:  st_d = ST_RXUP;
        ST_RXUP:   st_d = next_phase(mode_q, 2'd2);
        ST_FDROP:  st_d = ST_FACK;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  assign finish  = step_ok && (st_d == ST_IDLE);
  assign restart = (st_d != st_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= '0;
      core_req_n <= 1'b0;
      tx_req_n   <= 1'b0;
      rx_req_n   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_step   <= '0;
    end else begin
      st_q <= st_d;
      done <= finish;
      if (start_acc) begin
        mode_q   <= mode;
        err      <= 1'b0;
        err_step <= '0;
        tx_req_n <= 1'b1;
        rx_req_n <= 1'b1;
      end
      if (st_q == ST_PREP) core_req_n <= 1'b1;
      if (step_ok) begin
        if (st_d == ST_TXDROP) tx_req_n   <= 1'b0;
        if (st_d == ST_RXDROP) rx_req_n   <= 1'b0;
        if (st_d == ST_FDROP)  core_req_n <= 1'b0;
        if (st_q == ST_TXACK)  tx_req_n   <= 1'b1;
        if (st_q == ST_RXACK)  rx_req_n   <= 1'b1;
      end
      if (tmo_hit) begin
        err        <= 1'b1;
        err_step   <= st_q;
        core_req_n <= 1'b0;
        tx_req_n   <= 1'b0;
        rx_req_n   <= 1'b0;
      end
    end
  end

  // R2
  core_rel_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_req_n) |-> (tx_req_n && rx_req_n));

  // R4
  tx_rel_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(tx_req_n) && $past(st_q) == ST_TXACK) |-> $past(!tx_ack_s));

  // R5
  rx_rel_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(rx_req_n) && $past(st_q) == ST_RXACK) |-> $past(!rx_ack_s));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> !done);

  // R9
  tmo_safe_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(err) |-> (!core_req_n && !tx_req_n && !rx_req_n && !busy && !done));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (err && !start_acc) |=> err);

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (busy && start) |=> $stable(mode_q));
endmodule

// File: rtl/rst_hs_seq.sv
module rst_hs_seq
  import rst_hs_pkg::*;
#(
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [TMO_W-1:0]  tmo_lim,
  input  logic              core_ack_n,
  input  logic              tx_ack_n,
  input  logic              rx_ack_n,
  input  logic              tx_stable,
  input  logic              rx_ready,
  output logic              core_req_n,
  output logic              tx_req_n,
  output logic              rx_req_n,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        err_step
);
  logic [NUM_SYNC-1:0] raw_in, sync_in;
  logic                restart, expire;

  always_comb begin
    raw_in          = '0;
    raw_in[SI_CACK] = core_ack_n;
    raw_in[SI_TACK] = tx_ack_n;
    raw_in[SI_RACK] = rx_ack_n;
    raw_in[SI_TST]  = tx_stable;
    raw_in[SI_RRDY] = rx_ready;
  end

  rst_hs_sync #(.W(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(raw_in), .q(sync_in));

  rst_hs_tmo #(.W(TMO_W)) u_tmo (
    .clk(clk), .arst_n(arst_n), .restart(restart), .lim(tmo_lim),
    .expire(expire));

  rst_hs_fsm u_fsm (
    .clk(clk), .arst_n(arst_n), .start(start), .mode(mode), .expire(expire),
    .core_ack_s(sync_in[SI_CACK]), .tx_ack_s(sync_in[SI_TACK]),
    .rx_ack_s(sync_in[SI_RACK]), .tx_st_s(sync_in[SI_TST]),
    .rx_rdy_s(sync_in[SI_RRDY]),
    .core_req_n(core_req_n), .tx_req_n(tx_req_n), .rx_req_n(rx_req_n),
    .busy(busy), .done(done), .err(err), .err_step(err_step),
    .restart(restart));
endmodule

// File: tb/rst_hs_seq_bench.sv
module rst_hs_seq_bench;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode_in = '0;
  logic [TW-1:0] tmo_lim = 16'd30;
  logic [4:0] mv;
  logic core_req_n, tx_req_n, rx_req_n, busy, done, err;
  logic [3:0] err_step;

  int n_chk = 0;
  int n_fail = 0;
  int stall_r = 0;
  int dl [5] = '{1, 1, 1, 1, 1};

  always #10 clk = ~clk;

  rst_hs_seq u_rst_hs_seq (
    .clk(clk), .arst_n(arst_n), .start(start), .mode(mode_in),
    .tmo_lim(tmo_lim), .core_ack_n(mv[0]), .tx_ack_n(mv[1]), .rx_ack_n(mv[2]),
    .tx_stable(mv[3]), .rx_ready(mv[4]), .core_req_n(core_req_n),
    .tx_req_n(tx_req_n), .rx_req_n(rx_req_n), .busy(busy), .done(done),
    .err(err), .err_step(err_step));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- core model: lagged responses with stall knobs ----------
  logic [4:0] tg;
  int lagc [5];
  logic tx_cyc, rx_cyc, pbm;

  always_comb begin
    tg[0] = core_req_n;
    if (stall_r == 2 && core_req_n) tg[0] = 1'b0;
    if (stall_r == 11 && !core_req_n) tg[0] = 1'b1;
    tg[1] = core_req_n && tx_req_n;
    if (stall_r == 5 && core_req_n && !tx_req_n) tg[1] = 1'b1;
    tg[2] = core_req_n && rx_req_n;
    if (stall_r == 8 && core_req_n && !rx_req_n) tg[2] = 1'b1;
    tg[3] = core_req_n && tx_req_n && mv[0] && mv[1];
    if ((stall_r == 4 || stall_r == 10) && mv[3]) tg[3] = 1'b1;
    if (stall_r == 6 && tx_cyc) tg[3] = 1'b0;
    tg[4] = core_req_n && rx_req_n && mv[0] && mv[2];
    if (stall_r == 3) tg[4] = 1'b0;
    if (stall_r == 7 && mv[4]) tg[4] = 1'b1;
    if (stall_r == 9 && rx_cyc) tg[4] = 1'b0;
  end

  always @(negedge clk) begin
    if (!arst_n) begin
      mv <= '0; tx_cyc <= 1'b0; rx_cyc <= 1'b0; pbm <= 1'b0;
      for (int i = 0; i < 5; i++) lagc[i] <= 0;
    end else begin
      pbm <= busy;
      if (busy && !pbm) begin
        tx_cyc <= 1'b0; rx_cyc <= 1'b0;
      end else begin
        if (busy && core_req_n && !tx_req_n) tx_cyc <= 1'b1;
        if (busy && core_req_n && !rx_req_n) rx_cyc <= 1'b1;
      end
      for (int i = 0; i < 5; i++) begin
        if (mv[i] != tg[i]) begin
          if (lagc[i] + 1 >= dl[i]) begin mv[i] <= tg[i]; lagc[i] <= 0; end
          else lagc[i] <= lagc[i] + 1;
        end else lagc[i] <= 0;
      end
    end
  end

  // ---------------- port monitor --------------------------------------------
  int ev [4];
  int ev_n, v_core, v_tx, v_rx, v_rdy, v_full, done_cnt, dbl;
  bit rdy_seen, txc, tdrop, tack, rxc, rdrop, rack, fc, fdrop, fack;
  logic pb = 0, pc = 0, pt = 0, pr = 0, pd = 0;

  always @(negedge clk) begin
    if (arst_n) begin
      if (busy && !pb) begin
        ev_n = 0; v_core = 0; v_tx = 0; v_rx = 0; v_rdy = 0; v_full = 0;
        done_cnt = 0; dbl = 0; rdy_seen = 0; txc = 0; rxc = 0; fc = 0;
      end
      if (busy && mv[3] && mv[4]) rdy_seen = 1;
      if (!pc && core_req_n && (!tx_req_n || !rx_req_n)) v_core++;
      if (txc && tx_req_n) begin if (!tack) v_tx++; txc = 0; end
      if (rxc && rx_req_n) begin if (!rack) v_rx++; rxc = 0; end
      if (pt && !tx_req_n && busy && core_req_n) begin
        if (ev_n < 4) ev[ev_n] = 1; ev_n++;
        txc = 1; tdrop = 0; tack = 0; if (!rdy_seen) v_rdy++;
      end
      if (pr && !rx_req_n && busy && core_req_n) begin
        if (ev_n < 4) ev[ev_n] = 2; ev_n++;
        rxc = 1; rdrop = 0; rack = 0; if (!rdy_seen) v_rdy++;
      end
      if (pc && !core_req_n && busy) begin
        if (ev_n < 4) ev[ev_n] = 3; ev_n++;
        fc = 1; fdrop = 0; fack = 0; if (!rdy_seen) v_rdy++;
      end
      if (txc) begin if (!mv[3]) tdrop = 1; if (tdrop && !mv[1]) tack = 1; end
      if (rxc) begin if (!mv[4]) rdrop = 1; if (rdrop && !mv[2]) rack = 1; end
      if (fc) begin if (!mv[3] && !mv[4]) fdrop = 1; if (fdrop && !mv[0]) fack = 1; end
      if (done) begin
        done_cnt++; if (pd) dbl++; if (!rdy_seen) v_rdy++;
        if (fc && !fack) v_full++;
      end
    end
    pb = busy; pc = core_req_n; pt = tx_req_n; pr = rx_req_n; pd = done;
  end

  // ---------------- expected-value helpers -----------------------------------
  function automatic int ord_at(input logic [2:0] m, input int idx);
    int k = 0;
    for (int b = 0; b < 3; b++) if (m[b]) begin
      if (k == idx) return b + 1;
      k++;
    end
    return 0;
  endfunction

  function automatic int tmo_span(input int lim);
    return lim + 1;
  endfunction

  task automatic run(input logic [2:0] m, input int stall, input int exp_step,
                     input int lim, input bit poke);
    int cr_at = -1, er_at = -1;
    stall_r = stall;
    tmo_lim = TW'(lim);
    for (int i = 0; i < 5; i++) dl[i] = 1 + int'($urandom % 5);
    @(negedge clk); mode_in = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b0 && err_step == 4'd0, "R11 start clears error", int'(err), 0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (poke && cyc == 1 && busy) begin start = 1'b1; mode_in = ~m; end
      else start = 1'b0;
      if (core_req_n && cr_at < 0) cr_at = cyc;
      if (err && er_at < 0) er_at = cyc;
      if (!busy && !start) break;
    end
    start = 1'b0;
    repeat (3) @(negedge clk);
    if (stall == 0) begin
      chk(done_cnt == 1 && dbl == 0, "R8 single done pulse", done_cnt, 1);
      chk(busy == 1'b0 && err == 1'b0, "R8 idle after run", int'(busy), 0);
      chk(v_core == 0, "R2 core release under datapath reset", v_core, 0);
      chk(v_rdy == 0, "R3 step before both ready", v_rdy, 0);
      if (m[0]) chk(v_tx == 0, "R4 TX release before ack", v_tx, 0);
      if (m[1]) chk(v_rx == 0, "R5 RX release before ack", v_rx, 0);
      chk(v_full == 0, "R6 done before full ack", v_full, 0);
      chk(core_req_n == !m[2] && tx_req_n && rx_req_n, "R6 final request levels",
          int'({core_req_n, tx_req_n, rx_req_n}), int'({!m[2], 2'b11}));
      chk(ev_n == int'($countones(m)), poke ? "R12 R7 cycle count" : "R7 cycle count",
          ev_n, int'($countones(m)));
      for (int i = 0; i < ev_n && i < 4; i++)
        chk(ev[i] == ord_at(m, i), poke ? "R12 R7 cycle order" : "R7 cycle order",
            ev[i], ord_at(m, i));
    end else begin
      chk(err == 1'b1 && done_cnt == 0 && !busy, "R9 timeout flag, no done",
          int'(err), 1);
      chk(!core_req_n && !tx_req_n && !rx_req_n, "R9 requests asserted",
          int'({core_req_n, tx_req_n, rx_req_n}), 0);
      chk(int'(err_step) == exp_step, "R10 failed step code", int'(err_step),
          exp_step);
      if (stall == 2)
        chk(er_at - cr_at == tmo_span(lim), "R9 timeout span", er_at - cr_at,
            tmo_span(lim));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1
    chk(!core_req_n && !tx_req_n && !rx_req_n, "R1 requests in reset",
        int'({core_req_n, tx_req_n, rx_req_n}), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!core_req_n && !tx_req_n && !rx_req_n && !busy && !done && !err &&
        err_step == 0, "R1 idle after reset", int'({busy, done, err}), 0);

    run(3'b111, 0, 0, 30, 0);
    run(3'b000, 0, 0, 30, 0);
    run(3'b100, 0, 0, 30, 0);
    run(3'b000, 2, 2, 7, 0);
    repeat (15) @(negedge clk);
    chk(err == 1'b1 && err_step == 4'd2, "R11 error held in idle", int'(err), 1);
    run(3'b011, 2, 2, 0, 0);
    run(3'b111, 3, 3, 30, 0);
    run(3'b001, 4, 4, 30, 0);
    run(3'b001, 5, 5, 30, 0);
    run(3'b001, 6, 6, 30, 0);
    run(3'b010, 7, 7, 30, 0);
    run(3'b010, 8, 8, 30, 0);
    run(3'b010, 9, 9, 30, 0);
    run(3'b100, 10, 10, 30, 0);
    run(3'b100, 11, 11, 30, 0);
    run(3'b011, 0, 0, 30, 1);
    for (int k = 0; k < 24; k++)
      run(3'($urandom % 8), 0, 0, 30 + int'($urandom % 20), bit'($urandom % 2));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule